// File: doc/BRIEF.md
# Calibration Retention Table Controller

This block keeps radio calibration results for several receive chains so they can be put back into the radio without running the calibration again. Each chain owns a small bank of six 28-bit words. The words are, in order, three DC-offset DAC settings (loop, low and high), a filter cutoff setting, the receive gain settings and a peak-detector offset. Software never addresses a word directly. It writes a per-chain data register when it writes a word, and it sets up a per-chain command word with an entry number, a direction bit and an access bit. It then polls the access bit until hardware drops it. A read returns its result in the same data register.

A global control register holds an enable bit, a per-entry restore mask and a force-restore bit. Setting the force-restore bit replays every masked entry of every chain onto a restore bus. Replay runs chain by chain, lowest entry first, one word per clock. The force-restore bit clears itself once the last word has gone out. To wipe the table of the active chains, software writes zero to each of their entries through the normal handshake and skips the inactive chains, which leaves them untouched.

Top module: `cal_ret_table`

## Requirements
- R1: After reset every register reads zero, every table word is zero and no restore beat is driven.
- R2: Register map on the 4-bit bus address. Address 0 is control: bit 0 enable, bits 6:1 restore mask (bit 1+i selects entry i), bit 7 force-restore. For chain c, address 1+2c is the command word: bit 0 access, bit 1 direction (1 = write), bits 4:2 entry. Address 2+2c is the data register, which keeps bits 27:0 of what is written. Every other address reads zero.
- R3: Writing a command with access = 1 while access is 0 starts an operation. Access reads 1 on the two reads that follow the command write and 0 on the third. A write operation then stores the data register into the selected entry.
- R4: A read operation loads the selected entry into the data register by the time access reads 0.
- R5: A command write that arrives while access is 1 is ignored: it changes neither the entry nor the direction, and it starts no operation.
- R6: Entries 6 and 7 complete the handshake normally. A write to them changes no table word, and a read from them returns zero in the data register.
- R7: Each chain has its own bank and its own registers. An operation on one chain never changes another chain's words or registers.
- R8: With enable = 1, setting force-restore emits the masked entries of chain 0, then chain 1, then chain 2, each chain in ascending entry order. The first beat appears the cycle after the control write and the beats follow on consecutive cycles. Force-restore reads 0 once the beats have ended.
- R9: With enable = 0, force-restore clears on the next clock and nothing is emitted. Table reads and writes still work while the block is disabled.
- R10: While force-restore is 1, writes to the control register are ignored.
- R11: Bus reads have one cycle of latency: read data reflects the register state at the first clock edge after the address is presented.
- R12: A restore with an all-zero mask emits nothing, and force-restore clears one clock after it was set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, one cycle after the address |
| replay_valid | output | 1 | Restore beat valid |
| replay_chain | output | 2 | Chain of the restore beat |
| replay_entry | output | 3 | Entry index of the restore beat |
| replay_word | output | 28 | Stored word being restored |

## Verification
A corrupted table word stays hidden until it is read or replayed. It then shows up in the data register or on the restore bus, so the bench reads back every entry and compares every replayed beat against its own model. A wrong handshake counter shows within three bus reads, because the access bit is polled on each of those reads. A wrong restore pointer shows on the first beat as a wrong chain, entry or order, or as a gap between beats. A stuck force-restore bit shows in the next control read.

// File: rtl/cal_ret_pkg.sv
package cal_ret_pkg;

    // Geometry of the retention store
    parameter int NUM_CHAINS  = 3;
    parameter int NUM_ENTRIES = 6;
    parameter int WORD_W      = 28;
    parameter int BUS_W       = 32;
    parameter int BUS_AW      = 4;

    localparam int ENTRY_AW  = 3;
    localparam int CHAIN_W   = (NUM_CHAINS > 1) ? $clog2(NUM_CHAINS) : 1;
    localparam int NUM_SLOTS = NUM_CHAINS * NUM_ENTRIES;
    localparam int SLOT_W    = $clog2(NUM_SLOTS + 1);

    // Command word bit positions
    localparam int CMD_ACC_BIT  = 0;
    localparam int CMD_WR_BIT   = 1;
    localparam int CMD_ENT_LSB  = 2;

    // Control register image: bit0 enable, mask above it, force on top
    typedef struct packed {
        logic                   force_rst;
        logic [NUM_ENTRIES-1:0] mask;
        logic                   enable;
    } ctrl_t;

    localparam int FORCE_BIT = $bits(ctrl_t) - 1;

    typedef struct packed {
        logic [ENTRY_AW-1:0] entry;
        logic                wr;
    } cmd_t;

    typedef struct packed {
        logic                valid;
        logic [CHAIN_W-1:0]  chain;
        logic [ENTRY_AW-1:0] idx;
        logic [WORD_W-1:0]   data;
    } beat_t;

    typedef struct packed {
        logic              found;
        logic [SLOT_W-1:0] slot;
    } hit_t;

    typedef logic [NUM_ENTRIES-1:0][WORD_W-1:0] bank_words_t;
    typedef logic [NUM_CHAINS-1:0][NUM_ENTRIES-1:0][WORD_W-1:0] all_words_t;

    localparam logic [BUS_AW-1:0] REG_CTRL = '0;

    function automatic logic [BUS_AW-1:0] cmd_addr(int c);
        return BUS_AW'(1 + 2 * c);
    endfunction

    function automatic logic [BUS_AW-1:0] data_addr(int c);
        return BUS_AW'(2 + 2 * c);
    endfunction

    // Lowest selected slot at or above 'from'
    function automatic hit_t find_next(logic [NUM_SLOTS-1:0] slots,
                                       logic [SLOT_W-1:0] from);
        hit_t h;
        h = '0;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (slots[s] && (SLOT_W'(s) >= from)) begin
                h.found = 1'b1;
                h.slot  = SLOT_W'(s);
            end
        end
        return h;
    endfunction

endpackage

// File: rtl/cal_ret_bank.sv
module cal_ret_bank
    import cal_ret_pkg::*;
#(
    parameter int ACCESS_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic              data_we,
    input  logic [WORD_W-1:0] wdata,
    output logic [BUS_W-1:0]  cmd_rb,
    output logic [WORD_W-1:0] data_rb,
    output bank_words_t       words
);

    localparam int CNT_W = $clog2(ACCESS_LAT + 1);

    logic              busy;
    logic [CNT_W-1:0]  cnt;
    cmd_t              cmd_q;
    logic [WORD_W-1:0] data_q;
    bank_words_t       mem;
    logic [WORD_W-1:0] sel_word;
    logic              in_range;

    assign in_range = (int'(cmd_q.entry) < NUM_ENTRIES);

    always_comb begin
        sel_word = '0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (cmd_q.entry == ENTRY_AW'(e)) sel_word = mem[e];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            cmd_q  <= '0;
            data_q <= '0;
            mem    <= '0;
        end else begin
            if (data_we) data_q <= wdata;
            if (!busy) begin
                if (cmd_we) begin
                    cmd_q.wr    <= wdata[CMD_WR_BIT];
                    cmd_q.entry <= wdata[CMD_ENT_LSB +: ENTRY_AW];
                    if (wdata[CMD_ACC_BIT]) begin
                        busy <= 1'b1;
                        cnt  <= CNT_W'(ACCESS_LAT - 1);
                    end
                end
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end else begin
                busy <= 1'b0;
                if (cmd_q.wr) begin
                    for (int e = 0; e < NUM_ENTRIES; e++) begin
                        if (cmd_q.entry == ENTRY_AW'(e)) mem[e] <= data_q;
                    end
                end else begin
                    data_q <= in_range ? sel_word : '0;
                end
            end
        end
    end

    assign cmd_rb  = {{(BUS_W - ENTRY_AW - 2){1'b0}}, cmd_q, busy};
    assign data_rb = data_q;
    assign words   = mem;

    // R3
    generate
        if (ACCESS_LAT >= 2) begin : g_hold
            access_hold_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(busy) |=> busy);
        end
    endgenerate

    // R5
    cmd_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cmd_q));

    // R6
    oob_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !cmd_q.wr && !in_range) |-> (data_q == '0));

    // R6
    oob_write_keep_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && cmd_q.wr && !in_range) |-> $stable(mem));

endmodule

// File: rtl/cal_ret_restore.sv
module cal_ret_restore
    import cal_ret_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic                   enable,
    input  logic [NUM_ENTRIES-1:0] mask,
    input  all_words_t             words,
    output logic                   busy,
    output beat_t                  beat
);

    logic                busy_q;
    logic [SLOT_W-1:0]   pos;
    logic [NUM_SLOTS-1:0] slots;
    hit_t                nxt;
    logic [CHAIN_W-1:0]  hit_chain;
    logic [ENTRY_AW-1:0] hit_idx;

    assign slots     = {NUM_CHAINS{mask}};
    assign nxt       = find_next(slots, pos);
    assign hit_chain = CHAIN_W'(int'(nxt.slot) / NUM_ENTRIES);
    assign hit_idx   = ENTRY_AW'(int'(nxt.slot) % NUM_ENTRIES);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            pos    <= '0;
            beat   <= '0;
        end else begin
            beat.valid <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    pos    <= '0;
                end
            end else if (!enable || !nxt.found) begin
                busy_q <= 1'b0;
            end else begin
                beat.valid <= 1'b1;
                beat.chain <= hit_chain;
                beat.idx   <= hit_idx;
                beat.data  <= words[hit_chain][hit_idx];
                pos        <= SLOT_W'(nxt.slot + 1'b1);
            end
        end
    end

    assign busy = busy_q;

    // R8
    beat_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        beat.valid |-> busy_q);

    // R8
    beat_masked_chk: assert property (@(posedge clk) disable iff (rst)
        beat.valid |-> mask[beat.idx]);

    // R8
    beat_order_chk: assert property (@(posedge clk) disable iff (rst)
        (beat.valid && $past(beat.valid)) |->
            ({beat.chain, beat.idx} > $past({beat.chain, beat.idx})));

    // R9
    disabled_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !enable) |=> (!busy_q && !beat.valid));

endmodule

// File: rtl/cal_ret_table.sv
module cal_ret_table
    import cal_ret_pkg::*;
#(
    parameter int ACCESS_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              replay_valid,
    output logic [CHAIN_W-1:0]  replay_chain,
    output logic [ENTRY_AW-1:0] replay_entry,
    output logic [WORD_W-1:0]   replay_word
);

    logic                   en_q;
    logic [NUM_ENTRIES-1:0] mask_q;
    logic                   rs_busy;
    logic                   ctrl_wr;
    logic                   rs_start;
    beat_t                  beat;
    ctrl_t                  ctrl_rb;
    all_words_t             all_words;
    logic [BUS_W-1:0]       cmd_rb  [NUM_CHAINS];
    logic [WORD_W-1:0]      data_rb [NUM_CHAINS];
    logic [BUS_W-1:0]       rd_sel;
    logic                   unused_hi;

    assign unused_hi = ^bus_wdata[BUS_W-1:WORD_W];

    // Control register: locked while a restore runs
    assign ctrl_wr  = bus_we && (bus_addr == REG_CTRL) && !rs_busy;
    assign rs_start = ctrl_wr && bus_wdata[FORCE_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            mask_q <= '0;
        end else if (ctrl_wr) begin
            en_q   <= bus_wdata[0];
            mask_q <= bus_wdata[1 +: NUM_ENTRIES];
        end
    end

    generate
        for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
            cal_ret_bank #(.ACCESS_LAT(ACCESS_LAT)) u_bank (
                .clk     (clk),
                .rst     (rst),
                .cmd_we  (bus_we && (bus_addr == cmd_addr(c))),
                .data_we (bus_we && (bus_addr == data_addr(c))),
                .wdata   (bus_wdata[WORD_W-1:0]),
                .cmd_rb  (cmd_rb[c]),
                .data_rb (data_rb[c]),
                .words   (all_words[c])
            );
        end
    endgenerate

    cal_ret_restore u_restore (
        .clk    (clk),
        .rst    (rst),
        .start  (rs_start),
        .enable (en_q),
        .mask   (mask_q),
        .words  (all_words),
        .busy   (rs_busy),
        .beat   (beat)
    );

    always_comb begin
        ctrl_rb.force_rst = rs_busy;
        ctrl_rb.mask      = mask_q;
        ctrl_rb.enable    = en_q;
        rd_sel = '0;
        if (bus_addr == REG_CTRL) rd_sel = {{(BUS_W - $bits(ctrl_t)){1'b0}}, ctrl_rb};
        for (int c = 0; c < NUM_CHAINS; c++) begin
            if (bus_addr == cmd_addr(c))  rd_sel = cmd_rb[c];
            if (bus_addr == data_addr(c)) rd_sel = {{(BUS_W - WORD_W){1'b0}}, data_rb[c]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= rd_sel;
    end

    assign replay_valid = beat.valid;
    assign replay_chain = beat.chain;
    assign replay_entry = beat.idx;
    assign replay_word  = beat.data;

    // R10
    ctrl_locked_chk: assert property (@(posedge clk) disable iff (rst)
        rs_busy |=> ($stable(en_q) && $stable(mask_q)));

    // R12
    empty_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (rs_busy && !replay_valid && mask_q == '0) |=> !rs_busy);

endmodule

// File: tb/tb_cal_ret_table.sv
module tb_cal_ret_table;
    import cal_ret_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [3:0]  bus_addr  = '0;
    logic        bus_we    = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        replay_valid;
    logic [1:0]  replay_chain;
    logic [2:0]  replay_entry;
    logic [27:0] replay_word;

    cal_ret_table dut (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .replay_valid(replay_valid), .replay_chain(replay_chain),
        .replay_entry(replay_entry), .replay_word(replay_word)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [27:0] model [3][6];

    typedef struct packed {
        logic [1:0]  ch;
        logic [2:0]  ix;
        logic [27:0] w;
    } exp_t;
    exp_t exp_q[$];

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    function automatic logic [3:0] ca(int c); return 4'(1 + 2 * c); endfunction
    function automatic logic [3:0] da(int c); return 4'(2 + 2 * c); endfunction

    // Each task starts and ends at a falling edge and takes one cycle
    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic table_op(input int c, input int e, input bit wr,
                            input logic [27:0] wd, output logic [27:0] rd);
        logic [31:0] r1, r2, r3, rv;
        if (wr) bus_write(da(c), {4'h0, wd});
        bus_write(ca(c), 32'((e << 2) | (int'(wr) << 1) | 1));
        bus_read(ca(c), r1);
        bus_read(ca(c), r2);
        bus_read(ca(c), r3);
        // R3 access held two reads, then clear
        chk(r1[0] && r2[0] && !r3[0], "R3 access handshake",
            {29'b0, r1[0], r2[0], r3[0]}, 32'b110);
        rd = '0;
        if (!wr) begin
            bus_read(da(c), rv);
            rd = rv[27:0];
        end
    endtask

    task automatic push_restore(input logic [5:0] m);
        for (int c = 0; c < 3; c++)
            for (int i = 0; i < 6; i++)
                if (m[i]) exp_q.push_back({2'(c), 3'(i), model[c][i]});
    endtask

    task automatic verify_all(input string req);
        logic [27:0] v;
        for (int c = 0; c < 3; c++)
            for (int e = 0; e < 6; e++) begin
                table_op(c, e, 1'b0, '0, v);
                chk(v === model[c][e], req, {4'h0, v}, {4'h0, model[c][e]});
            end
    endtask

    // Scoreboard monitor for restore beats
    always @(negedge clk) begin
        if (!rst && replay_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected restore beat",
                    {replay_chain, replay_entry, replay_word[26:0]}, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({replay_chain, replay_entry, replay_word} === e,
                    "R8 restore beat", {replay_chain, replay_entry, replay_word[26:0]},
                    {e.ch, e.ix, e.w[26:0]});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, r2;
        logic [27:0] v;
        int bad;
        for (int c = 0; c < 3; c++)
            for (int e = 0; e < 6; e++) model[c][e] = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state, R2 unmapped addresses read zero
        for (int a = 0; a < 16; a++) begin
            bus_read(4'(a), r);
            chk(r == 32'h0, "R1 register zero after reset", r, 32'h0);
        end
        chk(!replay_valid, "R1 no beat after reset", {31'b0, replay_valid}, 0);
        table_op(1, 4, 1'b0, '0, v);
        chk(v == '0, "R1 table word zero after reset", {4'h0, v}, 0);

        // R2 / R11 data register keeps low 28 bits, readable next cycle
        bus_write(da(0), 32'hFABCDEF1);
        bus_read(da(0), r);
        chk(r == 32'h0ABCDEF1, "R11 R2 data register readback", r, 32'h0ABCDEF1);
        bus_write(REG_CTRL, 32'h0000007E);
        bus_read(REG_CTRL, r);
        chk(r == 32'h7E, "R2 control readback", r, 32'h7E);
        bus_write(REG_CTRL, 32'h0);

        // R3 fill every entry, R4 read all back
        for (int c = 0; c < 3; c++)
            for (int e = 0; e < 6; e++) begin
                model[c][e] = 28'(32'h0100000 * (c + 1) + 32'h111 * e + 32'h3C);
                table_op(c, e, 1'b1, model[c][e], v);
            end
        bus_read(ca(2), r);
        chk(r == 32'((5 << 2) | 2), "R2 command readback after write", r, 32'((5 << 2) | 2));
        verify_all("R4 read returns stored word");

        // R5 command during access ignored
        bus_write(da(1), 32'h0DEAD01);
        bus_write(ca(1), 32'((1 << 2) | 3));
        bus_write(ca(1), 32'((2 << 2) | 3));
        bus_read(ca(1), r);
        bus_read(ca(1), r);
        chk(r == 32'((1 << 2) | 2), "R5 second command ignored", r, 32'((1 << 2) | 2));
        model[1][1] = 28'h0DEAD01;
        table_op(1, 2, 1'b0, '0, v);
        chk(v == model[1][2], "R5 entry 2 untouched", {4'h0, v}, {4'h0, model[1][2]});
        table_op(1, 1, 1'b0, '0, v);
        chk(v == model[1][1], "R5 entry 1 written", {4'h0, v}, {4'h0, model[1][1]});

        // R6 out-of-range entries
        table_op(2, 6, 1'b1, 28'h1234567, v);
        table_op(2, 5, 1'b0, '0, v);
        table_op(2, 7, 1'b0, '0, v);
        chk(v == '0, "R6 read of entry 7 returns zero", {4'h0, v}, 0);
        verify_all("R6 write to entry 6 changes nothing");

        // R7 clear active chains 0 and 2 only
        for (int c = 0; c < 3; c++) begin
            if (c != 1) begin
                for (int e = 0; e < 6; e++) begin
                    model[c][e] = '0;
                    table_op(c, e, 1'b1, '0, v);
                end
            end
        end
        verify_all("R7 inactive chain kept, active chains cleared");

        // reload distinct values for restore tests
        for (int c = 0; c < 3; c++)
            for (int e = 0; e < 6; e++) begin
                model[c][e] = 28'(32'h0A00000 + 32'h10000 * c + 32'h101 * e + 32'h7);
                table_op(c, e, 1'b1, model[c][e], v);
            end

        // R8 masked restore, consecutive beats
        push_restore(6'b101001);
        bus_write(REG_CTRL, 32'h80 | (32'h29 << 1) | 32'h1);
        bad = 0;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (replay_valid !== (k <= 9)) bad++;
        end
        chk(bad == 0, "R8 beat timing", bad, 0);
        chk(exp_q.size() == 0, "R8 all beats seen", exp_q.size(), 0);
        bus_read(REG_CTRL, r);
        chk(r == 32'h53, "R8 force cleared", r, 32'h53);

        // R12 empty mask
        bus_write(REG_CTRL, 32'h81);
        bus_read(REG_CTRL, r);
        bus_read(REG_CTRL, r2);
        chk(r == 32'h81 && r2 == 32'h01, "R12 force clears after one cycle", r2, 32'h01);

        // R9 disabled restore
        bus_write(REG_CTRL, 32'hFE);
        bus_read(REG_CTRL, r);
        bus_read(REG_CTRL, r2);
        chk(r == 32'hFE && r2 == 32'h7E, "R9 disabled force clears", r2, 32'h7E);
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R9 nothing emitted", exp_q.size(), 0);
        model[0][0] = 28'h0C0FFEE;
        table_op(0, 0, 1'b1, model[0][0], v);
        table_op(0, 0, 1'b0, '0, v);
        chk(v == model[0][0], "R9 table access while disabled", {4'h0, v}, {4'h0, model[0][0]});

        // R10 control locked during restore
        push_restore(6'h3F);
        bus_write(REG_CTRL, 32'hFF);
        bus_write(REG_CTRL, 32'h80);
        bus_read(REG_CTRL, r);
        chk(r == 32'hFF, "R10 control write ignored while running", r, 32'hFF);
        repeat (25) @(negedge clk);
        bus_read(REG_CTRL, r);
        chk(r == 32'h7F, "R10 control after restore", r, 32'h7F);
        chk(exp_q.size() == 0, "R10 full restore emitted", exp_q.size(), 0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule